// File: doc/BRIEF.md
# Running Mean Sequencer

This block averages between one and fifteen unsigned 8-bit values that sit on sixteen parallel input lanes. A pulse on `start` begins one computation. The controller clears a 12-bit running total. It then walks an index counter upward and adds the lane that the counter selects on each step. When the index equals the requested count, it hands the total to a restoring divider. The unit raises `done` when the truncated quotient is ready on `mean`.

The index counter can only count up and has no clear path, including reset. Before it signals completion, the controller keeps stepping the counter until it rolls over from 15 to 0. That wrap-back runs in parallel with the division, so the completion time is set by whichever of the two takes longer.

The controller is a one-hot machine with five named states:
- `S_IDLE` waits for `start` and moves to `S_CLEAR`.
- `S_CLEAR` zeroes the total and moves to `S_ACCUM`.
- `S_ACCUM` adds one lane per cycle while the index differs from `num`. When the index equals `num`, it pulses the divider start and moves to `S_FINISH`.
- `S_FINISH` steps the index while it is non-zero. It moves to `S_DONE` once the index is zero and the divider reports completion.
- `S_DONE` holds `done` high until `start` returns, then moves to `S_CLEAR`.

Top module: `mean_unit`

## Requirements
- R1: After a synchronous reset, `done` is 0 and `mean` is 0.
- R2: For every `num` from 1 to 15, `mean` equals floor((sum of lanes 0 to num-1) / num) when `done` rises. Lane i occupies bits 8*i+7 down to 8*i of `data_in`.
- R3: Lanes with an index of `num` or above have no effect on the result.
- R4: Counting the edge that samples `start` as edge 0, `done` is first high after edge max(19, num+15). The index is 0 whenever `done` is high.
- R5: Once high, `done` and `mean` hold until `start` is sampled. `done` is low after the edge that samples `start`.
- R6: A `start` pulse sampled while a computation is in progress has no effect on its result or its timing.
- R7: Consecutive computations with different `num` values each give the correct result with no reset between them.
- R8: With fifteen lanes at 255 the total does not overflow and the result is 255.
- R9: Exactly one state bit of the controller is set at all times outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset. The index counter is not reset |
| start | input | 1 | Begins a computation when sampled in the idle or done state |
| num | input | 4 | Number of lanes to average, 1 to 15 |
| data_in | input | 128 | Sixteen 8-bit lanes, lane i in bits 8*i+7:8*i |
| done | output | 1 | Result valid, held until the next start |
| mean | output | 8 | Truncated quotient of total by num |

## Verification
The hardest situation to reach from the ports is a counter that has not fully wrapped back. It shows only as a wrong result or a wrong completion time on the next run. The stimulus therefore runs every `num` from 1 to 15 back to back under several lane patterns, with no reset in between, and checks the exact completion cycle. That sweep covers both regimes: for small `num` the wrap-back sets the time, and for large `num` the divider does. Some runs also inject a stray `start` in the middle of the computation.

// File: rtl/mean_pkg.sv
package mean_pkg;
    localparam int LANES   = 16;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 4;
    localparam int TOTAL_W = 12;

    typedef enum logic [4:0] {
        S_IDLE   = 5'b00001,
        S_CLEAR  = 5'b00010,
        S_ACCUM  = 5'b00100,
        S_FINISH = 5'b01000,
        S_DONE   = 5'b10000
    } ctl_state_t;
endpackage

// File: rtl/mean_index_counter.sv
module mean_index_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         inc,
    output logic [W-1:0] idx
);
    // Increment-only counter with no clear. It relies on a power-up value of zero.
    logic [W-1:0] idx_q = '0;

    always_ff @(posedge clk) begin
        if (inc) idx_q <= idx_q + 1'b1;
    end

    assign idx = idx_q;
endmodule

// File: rtl/mean_accum.sv
module mean_accum #(
    parameter int LANES   = 16,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 4,
    parameter int TOTAL_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*DATA_W-1:0] data_in,
    output logic [TOTAL_W-1:0]      total
);
    localparam int PAD_W = TOTAL_W - DATA_W;

    logic [DATA_W-1:0]  lane [LANES];
    logic [DATA_W-1:0]  picked;
    logic [TOTAL_W-1:0] total_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = data_in[g*DATA_W +: DATA_W];
    end

    always_comb picked = lane[idx];

    always_ff @(posedge clk) begin
        if (rst || clr)  total_q <= '0;
        else if (load)   total_q <= total_q + {{PAD_W{1'b0}}, picked};
    end

    assign total = total_q;

    // R8: the running total never wraps.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        load |=> (total_q >= $past(total_q)));
endmodule

// File: rtl/mean_divider.sv
module mean_divider #(
    parameter int NW = 12,
    parameter int DW = 4,
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          fin,
    output logic [QW-1:0] quot
);
    localparam int CW = $clog2(NW);
    localparam logic [CW-1:0] LAST = CW'(NW - 1);

    logic [NW-1:0] q_q;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] dsr_q;
    logic [CW-1:0] step_q;
    logic          busy_q;
    logic          fin_q;
    logic [DW:0]   shifted;
    logic [DW:0]   diff;
    logic          fits;

    always_comb begin
        shifted = {rem_q, q_q[NW-1]};
        diff    = shifted - {1'b0, dsr_q};
        fits    = shifted >= {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else if (start) begin
            q_q    <= dividend;
            rem_q  <= '0;
            dsr_q  <= divisor;
            step_q <= '0;
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= fits ? diff[DW-1:0] : shifted[DW-1:0];
            q_q    <= {q_q[NW-2:0], fits};
            step_q <= step_q + 1'b1;
            if (step_q == LAST) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end
    end

    assign fin  = fin_q;
    assign quot = q_q[QW-1:0];

    // R5: a finished result stays put until a new start arrives.
    a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
        (fin_q && !start) |=> (fin_q && $stable(q_q)));
    // R5: a start withdraws completion on the next cycle.
    a_r5_start_clears_fin: assert property (@(posedge clk) disable iff (rst)
        start |=> (!fin_q && busy_q));
endmodule

// File: rtl/mean_ctrl.sv
module mean_ctrl
    import mean_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic idx_zero,
    input  logic div_fin,
    output logic clr,
    output logic load,
    output logic inc,
    output logic div_start,
    output logic done
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_CLEAR;
            S_CLEAR:  state_d = S_ACCUM;
            S_ACCUM:  if (stop) state_d = S_FINISH;
            S_FINISH: if (idx_zero && div_fin) state_d = S_DONE;
            S_DONE:   if (start) state_d = S_CLEAR;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        clr       = 1'b0;
        load      = 1'b0;
        inc       = 1'b0;
        div_start = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_CLEAR:  clr = 1'b1;
            S_ACCUM: begin
                if (stop) div_start = 1'b1;
                else begin
                    load = 1'b1;
                    inc  = 1'b1;
                end
            end
            S_FINISH: inc = !idx_zero;
            S_DONE:   done = 1'b1;
            default:  ;
        endcase
    end

    // R9: one-hot state register.
    a_r9_onehot_state: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);
endmodule

// File: rtl/mean_unit.sv
module mean_unit
    import mean_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [IDX_W-1:0]        num,
    input  logic [LANES*DATA_W-1:0] data_in,
    output logic                    done,
    output logic [DATA_W-1:0]       mean
);
    logic [IDX_W-1:0]   idx;
    logic [TOTAL_W-1:0] total;
    logic clr, load, inc, div_start, div_fin, stop, idx_zero;

    assign stop     = (idx == num);
    assign idx_zero = (idx == '0);

    mean_index_counter #(.W(IDX_W)) u_idx (
        .clk (clk),
        .inc (inc),
        .idx (idx)
    );

    mean_accum #(
        .LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W), .TOTAL_W(TOTAL_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .load    (load),
        .idx     (idx),
        .data_in (data_in),
        .total   (total)
    );

    mean_divider #(.NW(TOTAL_W), .DW(IDX_W), .QW(DATA_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (total),
        .divisor  (num),
        .fin      (div_fin),
        .quot     (mean)
    );

    mean_ctrl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .idx_zero  (idx_zero),
        .div_fin   (div_fin),
        .clr       (clr),
        .load      (load),
        .inc       (inc),
        .div_start (div_start),
        .done      (done)
    );

    // R4: completion is only reported with the index back at zero.
    a_r4_done_idx_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (idx == '0));
    // R3: no lane at or beyond the count is ever added.
    a_r3_no_add_at_stop: assert property (@(posedge clk) disable iff (rst)
        load |-> (idx != num));
endmodule

// File: tb/tb_mean_unit.sv
`timescale 1ns/1ps
module tb_mean_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   num = 4'd1;
    logic [127:0] data_in = '0;
    logic         done;
    logic [7:0]   mean;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mean_unit dut (
        .clk(clk), .rst(rst), .start(start), .num(num),
        .data_in(data_in), .done(done), .mean(mean)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_val(input int p, input int i, input int n);
        case (p)
            0:       return 255;
            1:       return (i * 17 + 3) % 256;
            2:       return (i * 37 + n * 53 + 5) % 256;
            default: return (i < n) ? 0 : 255;
        endcase
    endfunction

    task automatic run(input int n, input int p, input bit inject);
        int sum = 0;
        int cnt = 0;
        int exp_lat;
        int exp_mean;
        logic [7:0] held;
        for (int i = 0; i < 16; i++) begin
            data_in[i*8 +: 8] = 8'(lane_val(p, i, n));
            if (i < n) sum += lane_val(p, i, n);
        end
        num = 4'(n);
        exp_mean = sum / n;
        exp_lat = (n + 15 > 19) ? n + 15 : 19;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R5 done drops after start", int'(done), 0);
        while (!done && cnt < 100) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            start = (inject && cnt == 3);
        end
        start = 1'b0;
        // R2 R3 R7 R8 result; R4 and R6 completion timing
        check(p == 3 ? "R3 ignored lanes" : (p == 0 ? "R8 max lanes" : "R2 R7 mean"),
              int'(mean), exp_mean);
        check(inject ? "R6 stray start latency" : "R4 latency", cnt, exp_lat);
        held = mean;
        repeat (4) @(negedge clk);
        check("R5 done held", int'(done), 1);
        check("R5 mean held", int'(mean), int'(held));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 mean after reset", int'(mean), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 15; n++) begin
                run(n, p, (p == 1) && (n % 3 == 0));
            end
        end
        // R7: decreasing counts after the sweep
        for (int n = 15; n >= 1; n -= 4) run(n, 2, 1'b0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule